// File: doc/BRIEF.md
# Shared Output Queue Block Controller

This controller manages one central cell memory on behalf of a group of four output ports. Each port has a small tail buffer that gathers arriving cells and a small head buffer that feeds its output link. Cells move between those buffers and the shared memory only in whole blocks of fixed-length cells. The controller handles the block bookkeeping. It keeps a pool of free block addresses and one linked list of blocks per port. Once per cycle it decides which single transfer happens and reports that transfer as a registered strobe. The strobe carries a kind code, the port and the block address, and the surrounding datapath then moves the cells.

A tail buffer that holds a complete block raises its write request line. A head buffer that runs low raises its read request line. Each port also reports whether its tail buffer holds any cells at all. When a port's queue in shared memory is empty, a read request is served by moving cells straight from tail to head, so a lightly loaded port never pays a trip through the shared memory. Storage therefore follows the load on each port, with no fixed per-port split of the memory.

Top module: `shq_ctrl`

## Requirements
- R1: After reset, `xfer_kind` is 0 (idle), `xfer_port` and `xfer_blk` are 0, `full` is low and every port queue is empty. Kind codes: 0 idle, 1 store (tail to shared memory), 2 fetch (shared memory to head), 3 bypass (tail straight to head). Port and block fields read 0 on idle, and the block field reads 0 on bypass.
- R2: A granted write takes its block from the free pool and shows it on `xfer_blk` one cycle after the request is sampled. From reset the pool hands out blocks 0, 1, 2 and so on in ascending order.
- R3: If any write request is eligible in a cycle, no read, fetch or bypass is granted in that cycle, whatever the read request lines say.
- R4: Write requests are served round-robin, and so are read requests. Each kind has its own pointer. After a port is selected, the search for that kind starts at the next higher port number and wraps around.
- R5: The blocks fetched for one port come out in the same order in which they were stored for that port.
- R6: A read request for a port whose shared queue is empty gives a bypass strobe if that port's `tail_busy` bit is high, and an idle cycle if it is low.
- R7: A write selected while no block is free produces no transfer (kind 0) and sets `full`.
- R8: While `full` is high, write requests are not considered. Read requests are served as if no write were pending.
- R9: `full` clears in the same cycle in which a fetch returns a block to the free pool.
- R10: A block returned by a fetch joins the end of the free pool and is handed out again after the blocks that were already free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 4 | Per-port request: the tail buffer holds a full block |
| rd_req | input | 4 | Per-port request: the head buffer wants a block |
| tail_busy | input | 4 | Per-port flag: the tail buffer holds at least one cell |
| xfer_kind | output | 2 | Transfer strobe: 0 idle, 1 store, 2 fetch, 3 bypass |
| xfer_port | output | 2 | Port served by the current transfer |
| xfer_blk | output | 4 | Shared-memory block address for store or fetch |
| full | output | 1 | Set by a write attempt that finds no free block |

## Verification
A write request and a read request can arrive in the same decision cycle. The bench provokes this by driving both kinds of request lines together. Directed steps cover the normal case and the case where `full` is already set, and a sweep covers every write and read pattern. The first case must yield a store, and the second must let the read through as a fetch that also clears `full`. A reference queue model in the bench predicts each strobe, port and block address, and every cycle is compared against it.

// File: rtl/shq_pkg.sv
package shq_pkg;

    typedef enum logic [1:0] {
        XK_IDLE   = 2'd0,
        XK_STORE  = 2'd1,
        XK_FETCH  = 2'd2,
        XK_BYPASS = 2'd3
    } xfer_kind_e;

    // Next port index after cur, wrapping at n.
    function automatic int wrap_next(input int cur, input int n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/shq_rr_arb.sv
module shq_rr_arb #(
    parameter int N = 4,
    localparam int PW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic          hit,
    output logic [PW-1:0] sel
);
    always_comb begin
        int k;
        hit = 1'b0;
        sel = '0;
        // Descending scan: the smallest offset from ptr wins last.
        for (int i = N - 1; i >= 0; i--) begin
            k = int'(ptr) + i;
            if (k >= N) k = k - N;
            if (req[k]) begin
                hit = 1'b1;
                sel = PW'(k);
            end
        end
    end
endmodule

// File: rtl/shq_link_lists.sv
module shq_link_lists #(
    parameter int NPORT = 4,
    parameter int NBLK  = 16,
    localparam int PW = $clog2(NPORT),
    localparam int BW = $clog2(NBLK),
    localparam int CW = BW + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       alloc_en,
    input  logic [PW-1:0]              alloc_port,
    input  logic                       rel_en,
    input  logic [PW-1:0]              rel_port,
    output logic [BW-1:0]              free_top,
    output logic [CW-1:0]              free_cnt,
    output logic [NPORT-1:0]           q_busy,
    output logic [NPORT-1:0][BW-1:0]   q_front
);
    logic [BW-1:0]             nxt [NBLK];
    logic [BW-1:0]             ftl;
    logic [NPORT-1:0][BW-1:0]  qtl;
    logic [NPORT-1:0][CW-1:0]  qcnt;
    logic [BW-1:0]             rel_blk;

    assign rel_blk = q_front[rel_port];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) nxt[i] <= BW'(i + 1);
            free_top <= '0;
            ftl      <= BW'(NBLK - 1);
            free_cnt <= CW'(NBLK);
            q_front  <= '0;
            qtl      <= '0;
            qcnt     <= '0;
        end else if (alloc_en) begin
            free_top <= nxt[free_top];
            free_cnt <= free_cnt - 1'b1;
            if (qcnt[alloc_port] == '0) q_front[alloc_port] <= free_top;
            else                        nxt[qtl[alloc_port]] <= free_top;
            qtl[alloc_port]  <= free_top;
            qcnt[alloc_port] <= qcnt[alloc_port] + 1'b1;
        end else if (rel_en) begin
            q_front[rel_port] <= nxt[rel_blk];
            qcnt[rel_port]    <= qcnt[rel_port] - 1'b1;
            if (free_cnt == '0) free_top <= rel_blk;
            else                nxt[ftl] <= rel_blk;
            ftl      <= rel_blk;
            free_cnt <= free_cnt + 1'b1;
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_busy
        assign q_busy[g] = (qcnt[g] != '0);
    end
endmodule

// File: rtl/shq_ctrl.sv
module shq_ctrl
    import shq_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int NBLK  = 16,
    localparam int PW = $clog2(NPORT),
    localparam int BW = $clog2(NBLK),
    localparam int CW = BW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] wr_req,
    input  logic [NPORT-1:0] rd_req,
    input  logic [NPORT-1:0] tail_busy,
    output logic [1:0]       xfer_kind,
    output logic [PW-1:0]    xfer_port,
    output logic [BW-1:0]    xfer_blk,
    output logic             full
);
    logic [PW-1:0] wptr, rptr, w_sel, r_sel, np;
    logic          w_hit, r_hit, w_step, r_step;
    logic          alloc_en, rel_en, set_full, clr_full;
    logic [BW-1:0] free_top, nb;
    logic [CW-1:0] free_cnt;
    logic [NPORT-1:0]         q_busy;
    logic [NPORT-1:0][BW-1:0] q_front;
    xfer_kind_e    nk;

    shq_rr_arb #(.N(NPORT)) u_warb (.req(wr_req), .ptr(wptr), .hit(w_hit), .sel(w_sel));
    shq_rr_arb #(.N(NPORT)) u_rarb (.req(rd_req), .ptr(rptr), .hit(r_hit), .sel(r_sel));

    shq_link_lists #(.NPORT(NPORT), .NBLK(NBLK)) u_lists (
        .clk(clk), .rst(rst),
        .alloc_en(alloc_en), .alloc_port(w_sel),
        .rel_en(rel_en), .rel_port(r_sel),
        .free_top(free_top), .free_cnt(free_cnt),
        .q_busy(q_busy), .q_front(q_front)
    );

    always_comb begin
        alloc_en = 1'b0; rel_en = 1'b0;
        set_full = 1'b0; clr_full = 1'b0;
        w_step = 1'b0; r_step = 1'b0;
        nk = XK_IDLE; np = '0; nb = '0;
        if (w_hit && !full) begin
            w_step = 1'b1;
            if (free_cnt == '0) begin
                set_full = 1'b1;
            end else begin
                alloc_en = 1'b1;
                nk = XK_STORE; np = w_sel; nb = free_top;
            end
        end else if (r_hit) begin
            r_step = 1'b1;
            if (q_busy[r_sel]) begin
                rel_en = 1'b1; clr_full = 1'b1;
                nk = XK_FETCH; np = r_sel; nb = q_front[r_sel];
            end else if (tail_busy[r_sel]) begin
                nk = XK_BYPASS; np = r_sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0; rptr <= '0; full <= 1'b0;
            xfer_kind <= XK_IDLE; xfer_port <= '0; xfer_blk <= '0;
        end else begin
            if (w_step) wptr <= PW'(wrap_next(int'(w_sel), NPORT));
            if (r_step) rptr <= PW'(wrap_next(int'(r_sel), NPORT));
            if (set_full)      full <= 1'b1;
            else if (clr_full) full <= 1'b0;
            xfer_kind <= nk;
            xfer_port <= np;
            xfer_blk  <= nb;
        end
    end
endmodule

// File: rtl/shq_ctrl_chk.sv
module shq_ctrl_chk #(
    parameter int NPORT = 4,
    parameter int NBLK  = 16,
    localparam int PW = $clog2(NPORT),
    localparam int BW = $clog2(NBLK),
    localparam int CW = BW + 1
) (
    input logic             clk,
    input logic             rst,
    input logic [NPORT-1:0] wr_req,
    input logic [NPORT-1:0] tail_busy,
    input logic [1:0]       xfer_kind,
    input logic [PW-1:0]    xfer_port,
    input logic             full,
    input logic [CW-1:0]    free_cnt
);
    assert_write_first_R3: assert property (@(posedge clk) disable iff (rst)
        ((wr_req != '0) && !full) |=> (xfer_kind != 2'd2 && xfer_kind != 2'd3));

    assert_no_room_R7: assert property (@(posedge clk) disable iff (rst)
        ((wr_req != '0) && !full && free_cnt == '0) |=> (full && xfer_kind == 2'd0));

    assert_hold_writes_R8: assert property (@(posedge clk) disable iff (rst)
        full |=> (xfer_kind != 2'd1));

    assert_fetch_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (xfer_kind == 2'd2) |-> !full);

    assert_store_takes_block_R2: assert property (@(posedge clk) disable iff (rst)
        (xfer_kind == 2'd1) |-> (free_cnt == $past(free_cnt) - 1'b1));

    assert_store_was_asked_R4: assert property (@(posedge clk) disable iff (rst)
        (xfer_kind == 2'd1) |-> ((($past(wr_req) >> xfer_port) & 1) != 0));

    assert_bypass_has_cells_R6: assert property (@(posedge clk) disable iff (rst)
        (xfer_kind == 2'd3) |-> ((($past(tail_busy) >> xfer_port) & 1) != 0));
endmodule

bind shq_ctrl shq_ctrl_chk #(.NPORT(NPORT), .NBLK(NBLK)) u_chk (
    .clk(clk), .rst(rst), .wr_req(wr_req), .tail_busy(tail_busy),
    .xfer_kind(xfer_kind), .xfer_port(xfer_port), .full(full),
    .free_cnt(free_cnt)
);

// File: tb/test_shq_ctrl.sv
module test_shq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] wr_req = '0, rd_req = '0, tail_busy = '0;
    logic [1:0] xfer_kind;
    logic [1:0] xfer_port;
    logic [3:0] xfer_blk;
    logic       full;

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    int m_free [16];
    int m_fhd = 0, m_fcnt = 16;
    int m_q [4][16];
    int m_qhd [4], m_qcnt [4];
    int m_wp = 0, m_rp = 0;
    bit m_full = 0;

    shq_ctrl i_shq_ctrl (
        .clk(clk), .rst(rst), .wr_req(wr_req), .rd_req(rd_req),
        .tail_busy(tail_busy), .xfer_kind(xfer_kind), .xfer_port(xfer_port),
        .xfer_blk(xfer_blk), .full(full)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int pick(input logic [3:0] req, input int ptr);
        for (int i = 0; i < 4; i++) if (req[(ptr + i) % 4]) return (ptr + i) % 4;
        return 0;
    endfunction

    task automatic check(input string tag, input int ak, input int ap, input int ab,
                         input int af, input int ek, input int ep, input int eb, input int ef);
        total++;
        if (ak != ek || ap != ep || ab != eb || af != ef) begin
            bad++;
            $display("FAIL %s: got kind=%0d port=%0d blk=%0d full=%0d, expected kind=%0d port=%0d blk=%0d full=%0d",
                     tag, ak, ap, ab, af, ek, ep, eb, ef);
        end
    endtask

    task automatic step(input logic [3:0] w, input logic [3:0] r, input logic [3:0] t,
                        input string tag);
        int ek, ep, eb, p, b;
        @(negedge clk);
        wr_req = w; rd_req = r; tail_busy = t;
        ek = 0; ep = 0; eb = 0;
        if (w != 0 && !m_full) begin
            p = pick(w, m_wp); m_wp = (p + 1) % 4;
            if (m_fcnt == 0) m_full = 1;
            else begin
                b = m_free[m_fhd]; m_fhd = (m_fhd + 1) % 16; m_fcnt--;
                m_q[p][(m_qhd[p] + m_qcnt[p]) % 16] = b; m_qcnt[p]++;
                ek = 1; ep = p; eb = b;
            end
        end else if (r != 0) begin
            p = pick(r, m_rp); m_rp = (p + 1) % 4;
            if (m_qcnt[p] > 0) begin
                b = m_q[p][m_qhd[p]]; m_qhd[p] = (m_qhd[p] + 1) % 16; m_qcnt[p]--;
                m_free[(m_fhd + m_fcnt) % 16] = b; m_fcnt++;
                m_full = 0;
                ek = 2; ep = p; eb = b;
            end else if (t[p]) begin
                ek = 3; ep = p;
            end
        end
        @(posedge clk);
        #1;
        check(tag, int'(xfer_kind), int'(xfer_port), int'(xfer_blk), int'(full),
              ek, ep, eb, int'(m_full));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got running, expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_free[i] = i;
        for (int p = 0; p < 4; p++) begin m_qhd[p] = 0; m_qcnt[p] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", int'(xfer_kind), int'(xfer_port), int'(xfer_blk), int'(full), 0, 0, 0, 0);

        step(4'b0000, 4'b0001, 4'b0000, "R6 empty no tail");
        step(4'b0000, 4'b0001, 4'b0001, "R6 bypass");
        step(4'b1111, 4'b0000, 4'b0000, "R2 first block");
        step(4'b1111, 4'b0000, 4'b0000, "R4 rr write");
        step(4'b1111, 4'b0000, 4'b0000, "R4 rr write");
        step(4'b1111, 4'b0000, 4'b0000, "R4 rr write");
        step(4'b0001, 4'b0001, 4'b0001, "R3 write wins");
        for (int i = 0; i < 11; i++) step(4'b0010, 4'b0000, 4'b0000, "R2 fill");
        step(4'b0010, 4'b0000, 4'b0000, "R7 no free block");
        step(4'b0010, 4'b0000, 4'b0000, "R8 writes held");
        step(4'b0010, 4'b0001, 4'b0000, "R9 fetch clears full");
        step(4'b0010, 4'b0000, 4'b0000, "R10 reuse returned block");
        for (int i = 0; i < 20; i++) step(4'b0000, 4'b1111, 4'b0000, "R5 drain order");
        step(4'b0000, 4'b0100, 4'b0100, "R6 bypass after drain");

        // sweep all write/read/tail patterns
        for (int pass = 0; pass < 3; pass++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] vb;
                vb = 8'(v);
                step((v % 3 == pass) ? vb[7:4] : 4'b0000, vb[3:0], vb[5:2], "R5 sweep");
            end
        end
        for (int i = 0; i < 24; i++) step(4'b0000, 4'b1111, 4'b1010, "R4 rr read drain");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule